// File: doc/BRIEF.md
# Configuration Window Decoder

This block turns the raw contents of the base address registers of one configuration header into address windows that downstream decode can use directly. There are six standard region registers and one expansion ROM register. Each comes with a static descriptor: a power-of-two size, where zero means the region is absent, and for the standard regions a flag that selects I/O or memory space. The block combines these with the I/O-space and memory-space enable bits of the command register. For each region it reports whether a window is live, and if so its first and last addresses.

Some computed windows cannot be used, and the block drops them. These are a base of zero, a window whose last address wraps to or below its base, an I/O window that reaches 0x10000 or above, and a memory window that ends at the all-ones address. Each region holds a registered copy of its current window. When the freshly computed window differs from that copy, the copy is replaced and a one-cycle change strobe is raised. Moving a live window straight to another live window takes two steps: first a withdrawal, then the new window. This way downstream logic never sees the old and new windows overlap.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, every region reports valid = 0, base and last = 0xFFFFFFFF, and change = 0.
- R2: For a usable region, base is the register value with its low log2(size) bits cleared, and last is base + size - 1.
- R3: A region with size 0 never becomes valid and never raises its change strobe.
- R4: A standard region flagged as I/O (is_io = 1) is live only while cmd_io_en = 1. A region flagged as memory, and the ROM region (index 6, whose I/O flag is ignored), is live only while cmd_mem_en = 1.
- R5: The ROM region (index 6) is live only when bit 0 of its register value is 1.
- R6: A window whose base is zero, or whose last address is not above its base (for example size 1), is reported unmapped.
- R7: An I/O window whose last address is 0x10000 or more is unmapped. A memory window whose last address is 0xFFFFFFFF is unmapped.
- R8: An unmapped region reports valid = 0, with base and last both reading 0xFFFFFFFF.
- R9: Outputs are registered. A new window appears on the clock edge after its inputs, together with a change strobe of exactly one cycle. No strobe is raised when the recomputed window equals the stored one, and regions are independent of each other.
- R10: A change from one live window to a different live window first shows one unmapped cycle with a strobe, then the new window with a second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_io_en | input | 1 | Command register I/O-space enable |
| cmd_mem_en | input | 1 | Command register memory-space enable |
| bar_val | input | 7x32 | Raw register values; index 6 is the ROM |
| reg_size | input | 7x32 | Region sizes, power of two or zero |
| reg_is_io | input | 7 | Region space flag, 1 = I/O (ignored for index 6) |
| win_valid | output | 7 | Window live |
| win_base | output | 7x32 | Window first address |
| win_last | output | 7x32 | Window last address |
| win_chg | output | 7 | One-cycle change strobe |

## Verification
Every result is due one clock edge after its inputs are driven. The exception is a live-to-live move, which shows its withdrawal one edge after the inputs and the new window one edge later. The bench drives inputs just after a falling edge and samples at the next falling edge, so each result is read half a cycle after the edge that produces it. Each table vector starts from an unmapped region, so its strobe is due exactly when its window is. A second sample one cycle later confirms that the strobe has dropped.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;
    localparam int AW = 32;
    localparam logic [AW-1:0] IO_TOP = 32'h0001_0000;
    localparam logic [AW-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] base;
        logic [AW-1:0] last;
    } win_t;

    function automatic win_t win_none();
        win_t w;
        w.valid = 1'b0;
        w.base  = ALL_ONES;
        w.last  = ALL_ONES;
        return w;
    endfunction

    function automatic logic [AW-1:0] size_mask(input logic [AW-1:0] size);
        return ~(size - 1'b1);
    endfunction
endpackage

// File: rtl/bar_win_calc.sv
module bar_win_calc
    import bar_win_pkg::*;
#(
    parameter bit IS_ROM = 1'b0
) (
    input  logic          io_en,
    input  logic          mem_en,
    input  logic [AW-1:0] raw,
    input  logic [AW-1:0] size,
    input  logic          is_io,
    output win_t          win
);
    logic          use_io;
    logic          enabled;
    logic [AW-1:0] base;
    logic [AW-1:0] last;
    logic          bad;

    always_comb begin
        use_io  = is_io && !IS_ROM;
        enabled = use_io ? io_en : mem_en;
        if (IS_ROM) begin
            enabled = enabled && raw[0];
        end
        base = raw & size_mask(size);
        last = base + size - 1'b1;
        bad  = (size == '0) || (base == '0) || (last <= base);
        if (use_io) begin
            bad = bad || (last >= IO_TOP);
        end else begin
            bad = bad || (last == ALL_ONES);
        end
        if (enabled && !bad) begin
            win.valid = 1'b1;
            win.base  = base;
            win.last  = last;
        end else begin
            win = win_none();
        end
    end
endmodule

// File: rtl/bar_win_track.sv
module bar_win_track
    import bar_win_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  win_t nxt,
    output win_t cur,
    output logic chg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= win_none();
            chg <= 1'b0;
        end else if (nxt != cur) begin
            chg <= 1'b1;
            if (cur.valid && nxt.valid) begin
                cur <= win_none();
            end else begin
                cur <= nxt;
            end
        end else begin
            chg <= 1'b0;
        end
    end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_win_pkg::*;
#(
    parameter int NUM_STD = 6,
    localparam int NREG = NUM_STD + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_io_en,
    input  logic                     cmd_mem_en,
    input  logic [NREG-1:0][AW-1:0]  bar_val,
    input  logic [NREG-1:0][AW-1:0]  reg_size,
    input  logic [NREG-1:0]          reg_is_io,
    output logic [NREG-1:0]          win_valid,
    output logic [NREG-1:0][AW-1:0]  win_base,
    output logic [NREG-1:0][AW-1:0]  win_last,
    output logic [NREG-1:0]          win_chg
);
    win_t nxt_w [NREG];
    win_t cur_w [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        bar_win_calc #(.IS_ROM(r == NUM_STD)) u_calc (
            .io_en  (cmd_io_en),
            .mem_en (cmd_mem_en),
            .raw    (bar_val[r]),
            .size   (reg_size[r]),
            .is_io  (reg_is_io[r]),
            .win    (nxt_w[r])
        );
        bar_win_track u_track (
            .clk (clk),
            .rst (rst),
            .nxt (nxt_w[r]),
            .cur (cur_w[r]),
            .chg (win_chg[r])
        );
        assign win_valid[r] = cur_w[r].valid;
        assign win_base[r]  = cur_w[r].base;
        assign win_last[r]  = cur_w[r].last;
    end
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk
    import bar_win_pkg::*;
#(
    parameter int NUM_STD = 6,
    localparam int NREG = NUM_STD + 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NREG-1:0][AW-1:0]  bar_val,
    input logic [NREG-1:0][AW-1:0]  reg_size,
    input logic [NREG-1:0]          reg_is_io,
    input logic [NREG-1:0]          win_valid,
    input logic [NREG-1:0][AW-1:0]  win_base,
    input logic [NREG-1:0][AW-1:0]  win_last,
    input logic [NREG-1:0]          win_chg
);
    for (genvar r = 0; r < NREG; r++) begin : g_chk
        // R8: unmapped windows read all-ones
        a_r8_unmapped_ones: assert property (@(posedge clk) disable iff (rst)
            !win_valid[r] |-> (win_base[r] == ALL_ONES && win_last[r] == ALL_ONES));
        // R9: strobe coincides with a visible change
        a_r9_chg_marks_change: assert property (@(posedge clk) disable iff (rst)
            win_chg[r] |-> (win_valid[r] != $past(win_valid[r]) || win_base[r] != $past(win_base[r])
                            || win_last[r] != $past(win_last[r])));
        // R9: no change without strobe
        a_r9_quiet_stable: assert property (@(posedge clk) disable iff (rst)
            !win_chg[r] |-> ($stable(win_valid[r]) && $stable(win_base[r]) && $stable(win_last[r])));
        // R10: never a direct live-to-live swap
        a_r10_withdraw_first: assert property (@(posedge clk) disable iff (rst)
            (win_valid[r] && $past(win_valid[r])) |-> (win_base[r] == $past(win_base[r])));
        // R3: absent region stays unmapped
        a_r3_absent_unmapped: assert property (@(posedge clk) disable iff (rst)
            ($past(reg_size[r]) == '0) |-> !win_valid[r]);
        if (r < NUM_STD) begin : g_std
            // R7: I/O windows stay below the I/O limit
            a_r7_io_limit: assert property (@(posedge clk) disable iff (rst)
                (win_valid[r] && $past(reg_is_io[r])) |-> (win_last[r] < IO_TOP));
        end else begin : g_rom
            // R5: ROM needs its enable bit
            a_r5_rom_enable: assert property (@(posedge clk) disable iff (rst)
                win_valid[r] |-> $past(bar_val[r][0]));
        end
    end
endmodule

bind bar_window_decoder bar_window_decoder_chk #(.NUM_STD(NUM_STD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bar_val   (bar_val),
    .reg_size  (reg_size),
    .reg_is_io (reg_is_io),
    .win_valid (win_valid),
    .win_base  (win_base),
    .win_last  (win_last),
    .win_chg   (win_chg)
);

// File: tb/test_bar_window_decoder.sv
module test_bar_window_decoder;
    localparam int NREG = 7;
    localparam int ROM = 6;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        io;
        logic [31:0] size;
        logic [31:0] bar;
        logic        cio;
        logic        cmem;
        logic        ev;
        logic [31:0] eb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_1000, 32'h8000_0123, 1'b0, 1'b1, 1'b1, 32'h8000_0000}, // R2
        '{1'b0, 32'h0000_1000, 32'h8000_0123, 1'b1, 1'b0, 1'b0, ONES},          // R4
        '{1'b0, 32'h0000_1000, 32'h0000_0FFF, 1'b0, 1'b1, 1'b0, ONES},          // R6 base zero
        '{1'b0, 32'h0000_1000, 32'hFFFF_F000, 1'b0, 1'b1, 1'b0, ONES},          // R7 mem top
        '{1'b1, 32'h0000_0010, 32'h0000_C001, 1'b1, 1'b0, 1'b1, 32'h0000_C000}, // R2 io
        '{1'b1, 32'h0000_0010, 32'h0000_C001, 1'b0, 1'b1, 1'b0, ONES},          // R4 io gate
        '{1'b1, 32'h0000_0010, 32'h0000_FFF1, 1'b1, 1'b0, 1'b1, 32'h0000_FFF0}, // R7 io edge ok
        '{1'b1, 32'h0000_0010, 32'h0001_0001, 1'b1, 1'b0, 1'b0, ONES},          // R7 io over
        '{1'b0, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0, ONES},          // R3
        '{1'b0, 32'h0000_0001, 32'h0000_0100, 1'b0, 1'b1, 1'b0, ONES},          // R6 size one
        '{1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0, ONES}           // R7 last all-ones
    };

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  cmd_io_en;
    logic                  cmd_mem_en;
    logic [NREG-1:0][31:0] bar_val;
    logic [NREG-1:0][31:0] reg_size;
    logic [NREG-1:0]       reg_is_io;
    logic [NREG-1:0]       win_valid;
    logic [NREG-1:0][31:0] win_base;
    logic [NREG-1:0][31:0] win_last;
    logic [NREG-1:0]       win_chg;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bar_window_decoder i_bar_window_decoder (
        .clk(clk), .rst(rst), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .bar_val(bar_val), .reg_size(reg_size), .reg_is_io(reg_is_io),
        .win_valid(win_valid), .win_base(win_base), .win_last(win_last),
        .win_chg(win_chg)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_win(string tag, int r, logic v, logic [31:0] b, logic [31:0] l, logic c);
        chk({tag, " valid"}, 32'(win_valid[r]), 32'(v));
        chk({tag, " base"},  win_base[r], b);
        chk({tag, " last"},  win_last[r], l);
        chk({tag, " chg"},   32'(win_chg[r]), 32'(c));
    endtask

    initial begin
        rst = 1'b1;
        cmd_io_en = 1'b0;
        cmd_mem_en = 1'b0;
        bar_val = '0;
        reg_size = '0;
        reg_is_io = '0;
        @(negedge clk);
        tick();
        // R1: reset state
        for (int r = 0; r < NREG; r++) check_win("R1 reset", r, 1'b0, ONES, ONES, 1'b0);
        rst = 1'b0;
        tick();
        for (int r = 0; r < NREG; r++) check_win("R1 after reset", r, 1'b0, ONES, ONES, 1'b0);

        // vector walk on region 0 (R2 R3 R4 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            logic [31:0] el;
            cmd_io_en = 1'b0;
            cmd_mem_en = 1'b0;
            reg_size[0] = '0;
            tick();
            tick();
            reg_is_io[0] = VEC[i].io;
            reg_size[0] = VEC[i].size;
            bar_val[0] = VEC[i].bar;
            cmd_io_en = VEC[i].cio;
            cmd_mem_en = VEC[i].cmem;
            el = VEC[i].ev ? VEC[i].eb + VEC[i].size - 1 : ONES;
            tick();
            check_win($sformatf("R9 vec%0d", i), 0, VEC[i].ev, VEC[i].eb, el, VEC[i].ev);
            tick();
            chk($sformatf("R9 vec%0d strobe drop", i), 32'(win_chg[0]), 32'd0);
        end

        // R5: ROM enable bit and memory gate
        cmd_io_en = 1'b0;
        cmd_mem_en = 1'b1;
        reg_size = '0;
        reg_size[ROM] = 32'h0001_0000;
        reg_is_io[ROM] = 1'b1;
        bar_val[ROM] = 32'h000E_0000;
        tick();
        check_win("R5 rom disabled", ROM, 1'b0, ONES, ONES, 1'b0);
        bar_val[ROM] = 32'h000E_0001;
        tick();
        check_win("R5 rom enabled", ROM, 1'b1, 32'h000E_0000, 32'h000E_FFFF, 1'b1);
        cmd_io_en = 1'b1;
        cmd_mem_en = 1'b0;
        tick();
        check_win("R4 rom needs mem enable", ROM, 1'b0, ONES, ONES, 1'b1);

        // R10: live window moves via an unmapped cycle; R9 independence
        cmd_io_en = 1'b0;
        cmd_mem_en = 1'b1;
        reg_is_io = '0;
        reg_size[2] = 32'h0000_0100;
        bar_val[2] = 32'h4000_0000;
        reg_size[1] = 32'h0000_1000;
        bar_val[1] = 32'h2000_0000;
        tick();
        tick();
        check_win("R10 first window", 1, 1'b1, 32'h2000_0000, 32'h2000_0FFF, 1'b0);
        bar_val[1] = 32'h2000_0ABC;
        tick();
        check_win("R9 same window no strobe", 1, 1'b1, 32'h2000_0000, 32'h2000_0FFF, 1'b0);
        bar_val[1] = 32'h3000_0000;
        tick();
        check_win("R10 withdraw step", 1, 1'b0, ONES, ONES, 1'b1);
        check_win("R9 neighbour untouched", 2, 1'b1, 32'h4000_0000, 32'h4000_00FF, 1'b0);
        tick();
        check_win("R10 new window", 1, 1'b1, 32'h3000_0000, 32'h3000_0FFF, 1'b1);
        tick();
        check_win("R10 settled", 1, 1'b1, 32'h3000_0000, 32'h3000_0FFF, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule